// File: doc/BRIEF.md
# Single-Wire Slave Addressing Layer

This block is the addressing state machine of a slave on a single-wire bus. It sits on top of a bit-slot layer. That layer turns the analog waveform into three kinds of one-cycle strobes: a bus reset was detected, a bit was written by the master, or the master opened a read slot that the device must answer. The addressing layer answers a read slot through a drive-enable and a bit value. When the enable is low the slot layer leaves the line released, and the master reads a 1.

After every bus reset the layer collects an 8-bit command, least significant bit first. It then runs one of five addressing sequences against a 64-bit identity fixed at build time. The identity holds a family byte in its low eight bits, a 48-bit serial number above that, and a check byte in its top eight bits. The sequences are: read the identity, match it, skip it, search, and search only when the local alarm flag is set. A read, match or skip that succeeds raises `selected` for the function-command layer. A device that loses a match or a search arbitration, or that receives an unknown code, stays silent until the next bus reset.

Top module: `owRomSelect`

## Requirements
- R1: After `rstN` the layer is idle: it ignores written bits and read slots until the first bus reset. A bus reset in any state clears `selected`, makes the device stop driving (`txEn`=0), and restarts command reception. When a bus reset arrives in the same cycle as a written bit, the reset wins.
- R2: The command is the next 8 written bits after a bus reset, first bit = bit 0. The codes 33h, 55h, CCh, F0h and ECh are recognised. Any other code leaves the device idle: `txEn`=0 and `selected`=0, whatever bits or slots follow.
- R3: After 33h the device answers 64 read slots. In slot i it drives `txEn`=1 and `txBit` = identity bit i, starting at bit 0, so the family byte goes out first and the check byte last. After the 64th slot `selected`=1.
- R4: After 55h the device takes 64 written bits. If written bit i equals identity bit i for every i, then `selected`=1 after the 64th bit.
- R5: During a match, the first written bit that differs from the identity makes the device idle until the next bus reset. `selected` stays 0 even after more bits are written.
- R6: After CCh, `selected`=1 in the cycle after the 8th command bit. It stays 1 until a bus reset.
- R7: After F0h, for each identity bit i in order, the device answers one read slot with bit i and a second read slot with its complement, and then takes one written bit. After all 64 rounds the device is idle with `selected`=0.
- R8: During a search, a written bit that differs from identity bit i makes the device stop driving (`txEn`=0) for all later slots until a bus reset.
- R9: ECh behaves exactly like F0h when `alarmFlag` is 1 at the 8th command bit. When `alarmFlag` is 0 the device goes idle instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | One-cycle strobe: a bus reset was detected |
| rxValid | input | 1 | One-cycle strobe: the master wrote a bit |
| rxBit | input | 1 | Value of the written bit, valid with `rxValid` |
| slotReq | input | 1 | One-cycle strobe: a read slot is being answered with the current `txEn`/`txBit` |
| alarmFlag | input | 1 | Alarm condition from the measurement side, used by ECh |
| txEn | output | 1 | Device drives the current read slot |
| txBit | output | 1 | Value for the current read slot (1 when `txEn` is 0) |
| selected | output | 1 | Device is addressed for function commands |

## Verification
Every strobe is taken on one rising edge. `txEn`, `txBit` and `selected` are decoded from the state registered on that edge, so each result is due exactly one cycle after its strobe, with no extra pipeline stage. The bench drives a strobe at a falling edge, drops it at the next falling edge, and reads the outputs there, one cycle later. For a read slot, the answer value is sampled at the falling edge just before the slot strobe is raised, which is the value the slot layer would put on the line.

// File: rtl/owRomPkg.sv
package owRomPkg;
  localparam int ID_BITS = 64;
  localparam int IDX_W   = $clog2(ID_BITS);
  localparam int CMD_W   = 8;

  localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_ALARM  = 8'hEC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_SBIT, ST_SCMP, ST_SDIR, ST_SEL
  } romState_e;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftCmd;
  } pathCtl_t;
endpackage

// File: rtl/owRomPath.sv
module owRomPath
  import owRomPkg::*;
#(
  parameter logic [ID_BITS-1:0] ID_CODE = 64'hB40000DEADBEEF28
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         ctl,
  input  logic             rxBit,
  output logic [CMD_W-1:0] cmdNext,
  output logic             cmdLast,
  output logic [IDX_W-1:0] bitIdx,
  output logic             idxLast,
  output logic             idBit
);
  logic [CMD_W-1:0] cmdReg;
  logic [IDX_W-1:0] cnt;

  // one counter serves both command bits and identity bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clrCnt) begin
      cnt <= '0;
    end else if (ctl.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  // LSB-first command assembly: new bit enters at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (ctl.shiftCmd) begin
      cmdReg <= cmdNext;
    end
  end

  assign cmdNext = {rxBit, cmdReg[CMD_W-1:1]};
  assign cmdLast = (cnt == IDX_W'(CMD_W - 1));
  assign idxLast = (cnt == IDX_W'(ID_BITS - 1));
  assign bitIdx  = cnt;
  assign idBit   = ID_CODE[cnt];
endmodule

// File: rtl/owRomCtrl.sv
module owRomCtrl
  import owRomPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             rxValid,
  input  logic             rxBit,
  input  logic             slotReq,
  input  logic             alarmFlag,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic             cmdLast,
  input  logic             idxLast,
  input  logic             idBit,
  output pathCtl_t         ctl,
  output romState_e        state,
  output logic             txEn,
  output logic             txBit,
  output logic             selected
);
  romState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  function automatic romState_e decodeCmd(input logic [CMD_W-1:0] code, input logic alarm);
    unique case (code)
      CMD_READ:   decodeCmd = ST_READ;
      CMD_MATCH:  decodeCmd = ST_MATCH;
      CMD_SKIP:   decodeCmd = ST_SEL;
      CMD_SEARCH: decodeCmd = ST_SBIT;
      CMD_ALARM:  decodeCmd = alarm ? ST_SBIT : ST_IDLE;
      default:    decodeCmd = ST_IDLE;
    endcase
  endfunction

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (busReset) begin
      nextState  = ST_CMD;
      ctl.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_CMD: if (rxValid) begin
          ctl.shiftCmd = 1'b1;
          if (cmdLast) begin
            ctl.clrCnt = 1'b1;
            nextState  = decodeCmd(cmdNext, alarmFlag);
          end else begin
            ctl.incCnt = 1'b1;
          end
        end
        ST_READ: if (slotReq) begin
          if (idxLast) nextState = ST_SEL;
          else         ctl.incCnt = 1'b1;
        end
        ST_MATCH: if (rxValid) begin
          if (rxBit != idBit) nextState = ST_IDLE;
          else if (idxLast)   nextState = ST_SEL;
          else                ctl.incCnt = 1'b1;
        end
        ST_SBIT: if (slotReq) nextState = ST_SCMP;
        ST_SCMP: if (slotReq) nextState = ST_SDIR;
        ST_SDIR: if (rxValid) begin
          if (rxBit != idBit || idxLast) begin
            nextState = ST_IDLE;
          end else begin
            ctl.incCnt = 1'b1;
            nextState  = ST_SBIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    txEn  = 1'b0;
    txBit = 1'b1;
    unique case (state)
      ST_READ, ST_SBIT: begin txEn = 1'b1; txBit = idBit;  end
      ST_SCMP:          begin txEn = 1'b1; txBit = ~idBit; end
      default: ;
    endcase
  end

  assign selected = (state == ST_SEL);
endmodule

// File: rtl/owRomSelect.sv
module owRomSelect
  import owRomPkg::*;
#(
  parameter logic [ID_BITS-1:0] ID_CODE = 64'hB40000DEADBEEF28
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic rxValid,
  input  logic rxBit,
  input  logic slotReq,
  input  logic alarmFlag,
  output logic txEn,
  output logic txBit,
  output logic selected
);
  pathCtl_t         ctl;
  romState_e        ctrlState;
  logic [CMD_W-1:0] cmdNext;
  logic             cmdLast;
  logic             idxLast;
  logic             idBit;
  logic [IDX_W-1:0] bitIdx;

  owRomPath #(.ID_CODE(ID_CODE)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit),
    .cmdNext(cmdNext), .cmdLast(cmdLast), .bitIdx(bitIdx),
    .idxLast(idxLast), .idBit(idBit)
  );

  owRomCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxBit(rxBit), .slotReq(slotReq), .alarmFlag(alarmFlag),
    .cmdNext(cmdNext), .cmdLast(cmdLast), .idxLast(idxLast), .idBit(idBit),
    .ctl(ctl), .state(ctrlState), .txEn(txEn), .txBit(txBit), .selected(selected)
  );
endmodule

// File: rtl/owRomSelectChk.sv
module owRomSelectChk
  import owRomPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busReset,
  input logic             rxValid,
  input logic             rxBit,
  input logic             slotReq,
  input logic             selected,
  input logic             txEn,
  input romState_e        st,
  input logic [IDX_W-1:0] bitIdx,
  input logic             idBit
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!selected && !txEn && bitIdx == '0));

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !busReset) |=> selected);

  p_read_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_READ && slotReq && !busReset && bitIdx != IDX_W'(ID_BITS - 1))
      |=> (bitIdx == $past(bitIdx) + 1'b1));

  p_match_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_MATCH && rxValid && !busReset && rxBit != idBit)
      |=> (!selected && !txEn));

  p_search_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SDIR && rxValid && !busReset && bitIdx == IDX_W'(ID_BITS - 1))
      |=> (!selected && !txEn));
endmodule

bind owRomSelect owRomSelectChk uChk (
  .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
  .rxBit(rxBit), .slotReq(slotReq), .selected(selected), .txEn(txEn),
  .st(ctrlState), .bitIdx(bitIdx), .idBit(idBit)
);

// File: tb/sim_owRomSelect.sv
module sim_owRomSelect;
  localparam logic [63:0] ID = 64'hB40000DEADBEEF28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, rxValid = 1'b0, rxBit = 1'b0, slotReq = 1'b0, alarmFlag = 1'b0;
  logic txEn, txBit, selected;
  int   nTests = 0, nFail = 0;

  always #2 clk = ~clk;

  owRomSelect #(.ID_CODE(ID)) u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid), .rxBit(rxBit),
    .slotReq(slotReq), .alarmFlag(alarmFlag), .txEn(txEn), .txBit(txBit), .selected(selected)
  );

  // vector: {cmd[7:0], alarm, expSel, expTxEn} after the 8th command bit
  localparam logic [10:0] VEC [8] = '{
    {8'h33, 1'b0, 1'b0, 1'b1},
    {8'h55, 1'b0, 1'b0, 1'b0},
    {8'hCC, 1'b0, 1'b1, 1'b0},
    {8'hF0, 1'b0, 1'b0, 1'b1},
    {8'hEC, 1'b1, 1'b0, 1'b1},
    {8'hEC, 1'b0, 1'b0, 1'b0},
    {8'hA5, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doBusReset();
    @(negedge clk) busReset = 1'b1;
    @(negedge clk) busReset = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) begin rxValid = 1'b1; rxBit = b; end
    @(negedge clk) rxValid = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) sendBit(c[i]);
  endtask

  task automatic readSlot(output logic v);
    @(negedge clk) begin v = txEn ? txBit : 1'b1; slotReq = 1'b1; end
    @(negedge clk) slotReq = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    summary();
  end

  initial begin
    logic v, w;
    logic [63:0] got;
    logic ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, and idle until first bus reset
    check(!selected && !txEn, "R1 reset state", {selected, txEn}, 0);
    sendCmd(8'hCC);
    check(!selected, "R1 ignores bits before first bus reset", selected, 0);

    // table walk: R2 R6 R9 command decoding
    for (int k = 0; k < 8; k++) begin
      alarmFlag = VEC[k][2];
      doBusReset();
      check(!selected && !txEn, "R1 after bus reset", {selected, txEn}, 0);
      sendCmd(VEC[k][10:3]);
      check({selected, txEn} == VEC[k][1:0], "R2/R6/R9 command decode",
            {selected, txEn}, VEC[k][1:0]);
    end
    alarmFlag = 1'b0;

    // R2: unknown code ignores slots and bits
    doBusReset(); sendCmd(8'h5A);
    readSlot(v); sendCmd(8'hCC);
    check(v == 1'b1 && !selected, "R2 unknown code stays idle", {v, selected}, 2'b10);

    // R3: read identity
    doBusReset(); sendCmd(8'h33);
    got = '0;
    for (int i = 0; i < 64; i++) begin readSlot(v); got[i] = v; end
    check(got == ID, "R3 identity order", got, ID);
    check(got[7:0] == 8'h28, "R3 family byte first", got[7:0], 8'h28);
    check(selected, "R3 selected after read", selected, 1);

    // R1: bus reset clears selection
    doBusReset();
    check(!selected, "R1 reset clears selected", selected, 0);

    // R4: full match
    sendCmd(8'h55);
    for (int i = 0; i < 63; i++) sendBit(ID[i]);
    check(!selected, "R4 not selected before last bit", selected, 0);
    sendBit(ID[63]);
    check(selected, "R4 match selects", selected, 1);

    // R5: mismatch at bit 20
    doBusReset(); sendCmd(8'h55);
    for (int i = 0; i < 64; i++) sendBit(i == 20 ? ~ID[i] : ID[i]);
    check(!selected && !txEn, "R5 mismatch drops out", {selected, txEn}, 0);
    doBusReset(); sendCmd(8'hCC);
    check(selected, "R6 skip after recovery", selected, 1);
    sendBit(1'b0); readSlot(v);
    check(selected, "R6 stays selected", selected, 1);

    // R7: full search
    doBusReset(); sendCmd(8'hF0);
    ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      readSlot(v); readSlot(w);
      if (v != ID[i] || w != ~ID[i]) ok = 1'b0;
      sendBit(ID[i]);
    end
    check(ok, "R7 bit and complement per round", ok, 1);
    check(!selected && !txEn, "R7 idle after search", {selected, txEn}, 0);
    sendCmd(8'hCC);
    check(!selected, "R7 no command without reset", selected, 0);

    // R8: search drop out at bit 5
    doBusReset(); sendCmd(8'hF0);
    for (int i = 0; i < 5; i++) begin readSlot(v); readSlot(w); sendBit(ID[i]); end
    readSlot(v); readSlot(w); sendBit(~ID[5]);
    readSlot(v); readSlot(w);
    check(v && w && !txEn, "R8 released after loss", {v, w, txEn}, 3'b110);

    // R9: alarm search with flag runs search
    alarmFlag = 1'b1;
    doBusReset(); sendCmd(8'hEC);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      readSlot(v); readSlot(w);
      if (v != ID[i] || w != ~ID[i]) ok = 1'b0;
      sendBit(ID[i]);
    end
    check(ok, "R9 alarm search arbitrates", ok, 1);
    alarmFlag = 1'b0;

    // R1: reset wins over a concurrent written bit
    doBusReset();
    for (int i = 0; i < 7; i++) sendBit(8'hCC >> i);
    @(negedge clk) begin busReset = 1'b1; rxValid = 1'b1; rxBit = 1'b1; end
    @(negedge clk) begin busReset = 1'b0; rxValid = 1'b0; end
    check(!selected, "R1 reset beats bit", selected, 0);
    sendCmd(8'hCC);
    check(selected, "R1 count restarted", selected, 1);

    summary();
  end
endmodule